// File: doc/BRIEF.md
# Boot-Overlay System Address Decoder

This block sits between a 24-bit-address, big-endian processor bus and the memories of a small system. Each access carries an address, a transfer size (byte, word or long) and a read or write strobe. The block picks one of four regions for it: a computed read-only ROM image, main RAM, video RAM or a page-map RAM. It then returns or stores the bytes in big-endian order. The three writable regions are small internal byte arrays. Their decode windows are set by the memory map, but the arrays are smaller, so a window aliases onto its array through an index mask.

After reset the block is in boot-overlay mode. Address bit 23 is forced high on every access, so the processor fetches from ROM whatever address it issues. Software leaves overlay mode by writing a control location. The data bit that control write uses depends on the transfer size. A second write-only location drives four active-low front-panel LEDs.

Top module: `boot_map_decoder`

## Requirements
- R1: Reset puts the block in overlay mode, sets all `led_n` bits to 1 (all LEDs dark), clears `rdata` to zero and clears every byte of the RAM, video RAM and map RAM arrays to zero.
- R2: In overlay mode, address bit 23 is forced to 1 before decoding on every read and write. A read of 0x000100 therefore returns ROM byte 0x100, and a write to a low address leaves main RAM untouched.
- R3: A write to the control location 0xE43000, which is reachable in both modes, sets the mode. A byte write takes the mode from `wdata[7]` and a word or long write takes it from `wdata[15]`. A 1 selects normal decode and a 0 returns to overlay mode.
- R4: ROM answers 0x800000–0xBFFFFF and is checked first. The ROM byte at address a is 0xC3 ^ t[7:0] ^ t[15:8], where t = a & (ROM_SIZE-1), with ROM_SIZE = 16384. Writes to ROM are discarded.
- R5: Main RAM is checked second and answers any address below RAM_SIZE (0x80000). Its array index is the byte address masked by RAM_DEPTH-1, where RAM_DEPTH = 256.
- R6: Video RAM is checked third and answers 0x420000–0x427FFF. Map RAM is checked fourth and answers 0x400000–0x4007FF. Each is indexed by the byte address masked by its depth (256) minus one.
- R7: `size` is 0 for a byte, 1 for a word and 2 or 3 for a long. Data is right-aligned in `rdata` and `wdata`, with the upper unused bits of `rdata` reading as zero. The byte at the base address is the most significant. The region is chosen from the base address alone, and each byte address (base+k) is masked separately, so an access can wrap inside its region.
- R8: A read that hits no region returns all ones at the access width: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF. A write that hits no region and is not the control location or the LED location changes nothing.
- R9: `rdata` is loaded on the clock edge that samples `rd` and holds its value otherwise. Writes commit on the edge that samples `wr`. When `rd` and `wr` are both high in one cycle, the read returns the contents from before the write.
- R10: A word write (size 1) to 0x4A0000 in normal decode mode loads `led_n[3:0]` from `wdata[11:8]`, and a 0 bit lights its LED. Writes to that location of any other size, and any write to it in overlay mode (which redirects it to 0xCA0000), leave `led_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Byte address of the access |
| size | input | 2 | Transfer size: 0 byte, 1 word, 2/3 long |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Registered read data, right-aligned |
| led_n | output | 4 | Active-low LED drive |

## Verification
A read and a write can be sampled on the same edge, and the read must see the memory as it was before the write. The bench provokes this with directed read-write pairs to a RAM location that holds a known value, followed by a plain read. Random operations also raise both strobes together, and the reference model takes its expected read value before it applies the write. The same case is judged on the control location: a combined access there must decode its read under the mode that held before the write changed it.

// File: rtl/boot_map_decoder.sv
module boot_map_decoder #(
  parameter int unsigned RAM_SIZE   = 32'h80000,
  parameter int unsigned RAM_DEPTH  = 256,
  parameter int unsigned VRAM_DEPTH = 256,
  parameter int unsigned MAP_DEPTH  = 256,
  parameter int unsigned ROM_SIZE   = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] addr,
  input  logic [1:0]  size,
  input  logic        rd,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  led_n
);
  localparam int RAW = $clog2(RAM_DEPTH);
  localparam int VAW = $clog2(VRAM_DEPTH);
  localparam int MAW = $clog2(MAP_DEPTH);
  localparam logic [23:0] CTRL_LOC = 24'hE43000;
  localparam logic [23:0] LED_LOC  = 24'h4A0000;
  localparam logic [23:0] ROM_MASK = 24'(ROM_SIZE - 1);

  logic [7:0] ram_m  [RAM_DEPTH];
  logic [7:0] vram_m [VRAM_DEPTH];
  logic [7:0] map_m  [MAP_DEPTH];

  logic        map_en;
  logic [23:0] eff;
  logic        hit_rom, hit_ram, hit_vram, hit_map, hit_none;
  logic [2:0]  nbytes;
  logic [23:0] ba [4];
  logic [7:0]  rb [4];
  logic [7:0]  wb [4];
  logic [31:0] rd_word;

  function automatic logic [7:0] rom_byte(input logic [23:0] a);
    logic [23:0] t;
    t = a & ROM_MASK;
    return 8'hC3 ^ t[7:0] ^ t[15:8];
  endfunction

  assign eff      = map_en ? addr : (addr | 24'h800000);
  assign hit_rom  = (eff[23:22] == 2'b10);
  assign hit_ram  = !hit_rom && ({8'd0, eff} < RAM_SIZE);
  assign hit_vram = !hit_rom && !hit_ram && (eff[23:15] == 9'h084);
  assign hit_map  = !hit_rom && !hit_ram && !hit_vram && (eff[23:11] == 13'h0800);
  assign hit_none = !hit_rom && !hit_ram && !hit_vram && !hit_map;
  assign nbytes   = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ba[k] = eff + 24'(k);
      if (hit_rom)       rb[k] = rom_byte(ba[k]);
      else if (hit_ram)  rb[k] = ram_m[ba[k][RAW-1:0]];
      else if (hit_vram) rb[k] = vram_m[ba[k][VAW-1:0]];
      else if (hit_map)  rb[k] = map_m[ba[k][MAW-1:0]];
      else               rb[k] = 8'hFF;
    end
  end

  always_comb begin
    case (size)
      2'd0:    rd_word = {24'd0, rb[0]};
      2'd1:    rd_word = {16'd0, rb[0], rb[1]};
      default: rd_word = {rb[0], rb[1], rb[2], rb[3]};
    endcase
  end

  always_comb begin
    case (size)
      2'd0:    wb = '{wdata[7:0], 8'h00, 8'h00, 8'h00};
      2'd1:    wb = '{wdata[15:8], wdata[7:0], 8'h00, 8'h00};
      default: wb = '{wdata[31:24], wdata[23:16], wdata[15:8], wdata[7:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_en <= 1'b0;
      led_n  <= 4'hF;
      rdata  <= 32'd0;
      for (int i = 0; i < int'(RAM_DEPTH); i++)  ram_m[i]  <= 8'h00;
      for (int i = 0; i < int'(VRAM_DEPTH); i++) vram_m[i] <= 8'h00;
      for (int i = 0; i < int'(MAP_DEPTH); i++)  map_m[i]  <= 8'h00;
    end else begin
      if (rd) rdata <= rd_word;
      if (wr) begin
        for (int k = 0; k < 4; k++) begin
          if (k < int'(nbytes)) begin
            if (hit_ram)       ram_m[ba[k][RAW-1:0]]  <= wb[k];
            else if (hit_vram) vram_m[ba[k][VAW-1:0]] <= wb[k];
            else if (hit_map)  map_m[ba[k][MAW-1:0]]  <= wb[k];
          end
        end
        if (hit_none && eff == CTRL_LOC)
          map_en <= (size == 2'd0) ? wdata[7] : wdata[15];
        if (hit_none && eff == LED_LOC && size == 2'd1)
          led_n <= wdata[11:8];
      end
    end
  end
endmodule

module boot_map_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd,
  input logic        wr,
  input logic [1:0]  size,
  input logic [31:0] rdata,
  input logic [3:0]  led_n,
  input logic        map_en
);
  assert_byte_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && size == 2'd0 |=> rdata[31:8] == 24'd0);
  assert_word_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && size == 2'd1 |=> rdata[31:16] == 16'd0);
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  assert_led_word_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && size == 2'd1) |=> $stable(led_n));
  assert_led_overlay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |=> $stable(led_n));
  assert_mode_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(map_en) |-> $past(wr));
endmodule

bind boot_map_decoder boot_map_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .size(size),
  .rdata(rdata), .led_n(led_n), .map_en(map_en)
);

// File: tb/boot_map_decoder_tb.sv
`timescale 1ns/1ps
module boot_map_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] addr = 0;
  logic [1:0]  size = 0;
  logic        rd = 0, wr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  led_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  boot_map_decoder u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .size(size),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .led_n(led_n));

  logic [7:0] m_ram [256];
  logic [7:0] m_vram[256];
  logic [7:0] m_map [256];
  logic       m_norm;
  logic [3:0] m_led;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] m_eff(input logic [23:0] a);
    return m_norm ? a : (a | 24'h800000);
  endfunction

  function automatic int m_region(input logic [23:0] e);
    if (e >= 24'h800000 && e <= 24'hBFFFFF) return 0;
    if (e < 24'h080000) return 1;
    if (e >= 24'h420000 && e <= 24'h427FFF) return 2;
    if (e >= 24'h400000 && e <= 24'h4007FF) return 3;
    return 4;
  endfunction

  function automatic logic [7:0] m_byte(input int reg_id, input logic [23:0] a);
    logic [23:0] t;
    t = a & 24'h3FFF;
    case (reg_id)
      0: return 8'hC3 ^ t[7:0] ^ t[15:8];
      1: return m_ram[a[7:0]];
      2: return m_vram[a[7:0]];
      3: return m_map[a[7:0]];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int nb(input logic [1:0] s);
    return s == 0 ? 1 : s == 1 ? 2 : 4;
  endfunction

  function automatic logic [31:0] m_read(input logic [23:0] a, input logic [1:0] s);
    logic [23:0] e;
    logic [31:0] v;
    int r;
    e = m_eff(a); r = m_region(e); v = 0;
    for (int k = 0; k < nb(s); k++) v = {v[23:0], m_byte(r, e + 24'(k))};
    return v;
  endfunction

  task automatic m_write(input logic [23:0] a, input logic [1:0] s, input logic [31:0] d);
    logic [23:0] e;
    int r, n;
    e = m_eff(a); r = m_region(e); n = nb(s);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      logic [23:0] ba;
      b = 8'(d >> (8 * (n - 1 - k)));
      ba = e + 24'(k);
      if (r == 1) m_ram[ba[7:0]] = b;
      else if (r == 2) m_vram[ba[7:0]] = b;
      else if (r == 3) m_map[ba[7:0]] = b;
    end
    if (r == 4 && e == 24'hE43000) m_norm = (s == 0) ? d[7] : d[15];
    if (r == 4 && e == 24'h4A0000 && s == 1) m_led = d[11:8];
  endtask

  task automatic op(input logic [23:0] a, input logic [1:0] s, input logic dr,
                    input logic dw, input logic [31:0] d, input string tag);
    logic [31:0] exp;
    exp = dr ? m_read(a, s) : rdata;
    addr = a; size = s; rd = dr; wr = dw; wdata = d;
    @(posedge clk);
    if (dw) m_write(a, s, d);
    @(negedge clk);
    rd = 0; wr = 0;
    if (dr) check(tag, rdata, exp);
    check({tag, "/R10 led"}, {28'd0, led_n}, {28'd0, m_led});
  endtask

  initial begin
    #(100000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin m_ram[i] = 0; m_vram[i] = 0; m_map[i] = 0; end
    m_norm = 0; m_led = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rdata", rdata, 32'd0);
    check("R1 led", {28'd0, led_n}, 32'hF);

    op(24'h000100, 0, 1, 0, 0, "R2 overlay read");
    check("R2 literal", rdata, 32'h000000C2);
    op(24'h000010, 2, 0, 1, 32'h55667788, "R2 overlay write");
    op(24'h4A0000, 1, 0, 1, 32'h00000000, "R2 led redirected");
    op(24'hE43000, 0, 0, 1, 32'h00000080, "R3 byte bit7");
    op(24'h000010, 2, 1, 0, 0, "R3 normal mode");
    check("R2 ram untouched", rdata, 32'd0);
    op(24'h4A0000, 1, 0, 1, 32'h00000500, "R10 word led");
    check("R10 led value", {28'd0, led_n}, 32'h5);
    op(24'h4A0000, 0, 0, 1, 32'h000000FF, "R10 byte led ignored");
    op(24'h4A0000, 2, 0, 1, 32'hFFFFFFFF, "R10 long led ignored");
    op(24'h000010, 2, 0, 1, 32'h11223344, "R7 long write");
    op(24'h000010, 0, 1, 0, 0, "R7 byte0");
    check("R7 msb first", rdata, 32'h11);
    op(24'h000013, 0, 1, 0, 0, "R7 byte3");
    op(24'h000012, 1, 1, 0, 0, "R7 word");
    check("R7 word literal", rdata, 32'h3344);
    op(24'h0000FE, 2, 0, 1, 32'hA1B2C3D4, "R7 wrap write");
    op(24'h000000, 0, 1, 0, 0, "R7 wrap read");
    check("R7 wrap literal", rdata, 32'hC3);
    op(24'h000100, 0, 1, 0, 0, "R5 alias");
    op(24'h07FFFF, 0, 1, 0, 0, "R5 ram top");
    op(24'h080000, 0, 1, 0, 0, "R5 ram end R8");
    check("R8 byte ones", rdata, 32'hFF);
    op(24'h427FFF, 0, 0, 1, 32'h5E, "R6 vram top write");
    op(24'h427FFF, 0, 1, 0, 0, "R6 vram top read");
    op(24'h428000, 1, 1, 0, 0, "R6 vram end R8");
    check("R8 word ones", rdata, 32'hFFFF);
    op(24'h4007FE, 1, 0, 1, 32'h0000BEEF, "R6 map write");
    op(24'h4007FE, 1, 1, 0, 0, "R6 map read");
    op(24'h400800, 2, 1, 0, 0, "R6 map end R8");
    op(24'h600000, 3, 1, 0, 0, "R8 long ones");
    check("R8 long literal", rdata, 32'hFFFFFFFF);
    op(24'h800000, 2, 1, 0, 0, "R4 rom base");
    op(24'hBFFFFF, 0, 1, 0, 0, "R4 rom top");
    op(24'hC00000, 0, 1, 0, 0, "R4 rom end R8");
    op(24'h803FFE, 2, 1, 0, 0, "R4 rom wrap");
    op(24'h800004, 2, 0, 1, 32'h0, "R4 rom write");
    op(24'h800004, 2, 1, 0, 0, "R4 rom unchanged");
    op(24'h000020, 2, 0, 1, 32'h01020304, "R9 preload");
    op(24'h000020, 2, 1, 1, 32'hDEADBEEF, "R9 read before write");
    check("R9 old value", rdata, 32'h01020304);
    op(24'h000020, 2, 0, 0, 0, "R9 idle");
    check("R9 hold", rdata, 32'h01020304);
    op(24'h000020, 2, 1, 0, 0, "R9 committed");
    op(24'hE43000, 1, 0, 1, 32'h00000000, "R3 word clear");
    op(24'h000010, 2, 1, 0, 0, "R3 overlay again");
    op(24'hE43000, 2, 1, 1, 32'h00008000, "R3 long set with read");
    op(24'h000010, 2, 1, 0, 0, "R3 normal again");

    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      logic [1:0] s;
      logic dr, dw;
      logic [31:0] d;
      int cat;
      string tag;
      cat = int'($urandom % 9);
      case (cat)
        0: begin a = 24'h800000 | 24'($urandom % 24'h400000); tag = "R4 rnd"; end
        1, 2: begin a = 24'($urandom % 24'h80000); tag = "R5 rnd"; end
        3: begin a = 24'h420000 | 24'($urandom % 24'h8000); tag = "R6 rnd vram"; end
        4: begin a = 24'h400000 | 24'($urandom % 24'h800); tag = "R6 rnd map"; end
        5: begin a = 24'h600000 | 24'($urandom % 24'h10000); tag = "R8 rnd"; end
        6: begin a = 24'hE43000; tag = "R3 rnd"; end
        7: begin a = 24'h4A0000; tag = "R10 rnd"; end
        default: begin a = 24'($urandom); tag = "R2 rnd"; end
      endcase
      s = 2'($urandom % 4);
      dr = 1'($urandom % 2);
      dw = 1'($urandom % 2);
      if (cat == 6 && ($urandom % 4) != 0) d = 32'h00008080; else d = $urandom;
      op(a, s, dr, dw, d, tag);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule